// File: doc/BRIEF.md
# Single-Wire Debug Sync Pulse Responder

This block sits on the target side of a bidirectional single-wire debug pin. It watches the sampled pin level for a sync request from the host. A sync request is a low level held far longer than any low time that ordinary bit traffic produces. Once the block recognizes such a request, it waits for the host to let the pin go high again. It then answers with a precisely timed reply. By measuring that reply, the host learns the target's debug clock rate.

The reply has four steps. First comes a fixed settle delay, which gives the host time to stop its own high speedup drive. Next the block drives the pin low for a fixed number of debug clock cycles. It then drives the pin high for one cycle, which forces a sharp rising edge. Finally it releases the pin to high impedance. Outside this block, the drive-enable and drive-value outputs control a tri-state pad. A busy flag covers the whole span from recognition to release. After a reply, the block only starts watching for a new request once it has seen the released pin high.

Top module: `sync_pulse_responder`

## Requirements
- R1: A request is recognized on the rising clock edge at which `pin_level_i` has been sampled low on `SYNC_LOW_CYCLES` consecutive edges. From the following cycle, `busy_o` reads 1.
- R2: A low level sampled on fewer than `SYNC_LOW_CYCLES` consecutive edges has no effect. `busy_o` and `drive_en_o` stay 0 afterwards.
- R3: After recognition, and for as long as the pin stays low, the block stays busy and does not drive the pin (`drive_en_o` = 0).
- R4: After the first high sample that follows recognition, the block spends exactly `SETTLE_CYCLES` cycles busy with `drive_en_o` = 0.
- R5: The block then drives low (`drive_en_o` = 1, `drive_val_o` = 0) for exactly `PULSE_LOW_CYCLES` consecutive cycles.
- R6: Immediately after the low phase, it drives high (`drive_en_o` = 1, `drive_val_o` = 1) for exactly one cycle.
- R7: In the cycle after the high drive, `drive_en_o` and `busy_o` are both 0.
- R8: During the settle, low and high phases, the sampled pin level has no effect on phase lengths.
- R9: After release, the block does not recognize a new request until it has sampled the pin high. This holds even if the pin is held low for longer than `SYNC_LOW_CYCLES`. Once it has sampled the pin high, a full-length low is recognized again.
- R10: `drive_en_o` is 1 only while `busy_o` is 1. `busy_o` rises only after a low sample.
- R11: Taking `rst_n` low clears `drive_en_o` and `busy_o` at once, without waiting for a clock edge. Release of reset is synchronized internally by two flops. After reset the block is idle and ready to recognize a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pin_level_i | input | 1 | Sampled level of the debug pin |
| drive_en_o | output | 1 | Pad output enable; 0 = high impedance |
| drive_val_o | output | 1 | Level driven when enabled |
| busy_o | output | 1 | Request recognized, reply not yet released |

## Verification
The bench sweeps the low-pulse length across the detection threshold, from one cycle up to three beyond it.

- An off-by-one detector would answer a pulse one cycle short of the threshold, or miss the exact-threshold pulse.
- Phase lengths are measured cycle by cycle, so a counter that ends one cycle early or late shows up as a wrong settle, low or speedup length.
- The host pulls the pin low during the settle phase and holds it there past release. A block that listens while driving would stretch or restart its reply. A block that re-arms too early would answer that stale low with a second reply.
- Reset is applied mid-pulse to confirm the drive drops at once.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_HIGH = 3'd1,
    ST_SETTLE    = 3'd2,
    ST_DRIVE_LOW = 3'd3,
    ST_SPEEDUP   = 3'd4,
    ST_REARM     = 3'd5
  } wsr_state_e;

  function automatic int unsigned wsr_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wsr_rst_sync.sv
module wsr_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/wsr_low_detect.sv
module wsr_low_detect #(
  parameter int unsigned LIMIT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic pin_low_i,
  output logic hit_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;

  assign hit_o  = arm_i && pin_low_i && (run_q == LAST);
  assign run_en = arm_i || (run_q != '0);

  always_comb begin
    run_d = run_q;
    if (!arm_i || !pin_low_i || hit_o) begin
      run_d = '0;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/wsr_phase_timer.sv
module wsr_phase_timer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] cnt_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = run_i || clr_i || (cnt_q != '0);

  always_comb begin
    if (clr_i || !run_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sync_pulse_responder.sv
module sync_pulse_responder
  import wsr_pkg::*;
#(
  parameter int unsigned SYNC_LOW_CYCLES  = 512,
  parameter int unsigned SETTLE_CYCLES    = 16,
  parameter int unsigned PULSE_LOW_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_level_i,
  output logic drive_en_o,
  output logic drive_val_o,
  output logic busy_o
);

  localparam int unsigned TMR_MAX = wsr_max(SETTLE_CYCLES, PULSE_LOW_CYCLES);
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYCLES - 1);
  localparam logic [TMR_W-1:0] LOW_LAST    = TMR_W'(PULSE_LOW_CYCLES - 1);

  logic             rst_core_n;
  wsr_state_e       state_q;
  wsr_state_e       state_d;
  logic             req_hit;
  logic             tmr_run;
  logic             tmr_clr;
  logic [TMR_W-1:0] tmr_cnt;
  logic             settle_done;
  logic             low_done;

  // Reset: asynchronous assert, synchronized release
  wsr_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_core_n)
  );

  // Long-low request detector, armed only in idle
  wsr_low_detect #(
    .LIMIT (SYNC_LOW_CYCLES)
  ) u_low_detect (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .arm_i     (state_q == ST_IDLE),
    .pin_low_i (!pin_level_i),
    .hit_o     (req_hit)
  );

  // Shared timer for settle and low phases
  assign tmr_run     = (state_q == ST_SETTLE) || (state_q == ST_DRIVE_LOW);
  assign settle_done = (state_q == ST_SETTLE)    && (tmr_cnt == SETTLE_LAST);
  assign low_done    = (state_q == ST_DRIVE_LOW) && (tmr_cnt == LOW_LAST);
  assign tmr_clr     = settle_done || low_done;

  wsr_phase_timer #(
    .WIDTH (TMR_W)
  ) u_phase_timer (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run_i (tmr_run),
    .clr_i (tmr_clr),
    .cnt_o (tmr_cnt)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_hit)     state_d = ST_WAIT_HIGH;
      ST_WAIT_HIGH: if (pin_level_i) state_d = ST_SETTLE;
      ST_SETTLE:    if (settle_done) state_d = ST_DRIVE_LOW;
      ST_DRIVE_LOW: if (low_done)    state_d = ST_SPEEDUP;
      ST_SPEEDUP:                    state_d = ST_REARM;
      ST_REARM:     if (pin_level_i) state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Output decode from registered state
  always_comb begin
    drive_en_o  = 1'b0;
    drive_val_o = 1'b0;
    busy_o      = 1'b0;
    unique case (state_q)
      ST_WAIT_HIGH, ST_SETTLE: begin
        busy_o = 1'b1;
      end
      ST_DRIVE_LOW: begin
        busy_o     = 1'b1;
        drive_en_o = 1'b1;
      end
      ST_SPEEDUP: begin
        busy_o      = 1'b1;
        drive_en_o  = 1'b1;
        drive_val_o = 1'b1;
      end
      default: begin
        busy_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sync_pulse_responder_chk.sv
module sync_pulse_responder_chk #(
  parameter int unsigned PULSE_LOW_CYCLES = 128
) (
  input logic clk,
  input logic rst_n,
  input logic pin_level_i,
  input logic drive_en_o,
  input logic drive_val_o,
  input logic busy_o
);

  localparam int unsigned RW = $clog2(PULSE_LOW_CYCLES + 2);

  logic [RW-1:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
    end else if (drive_en_o && !drive_val_o) begin
      low_run_q <= low_run_q + 1'b1;
    end else begin
      low_run_q <= '0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!drive_en_o && !busy_o));  // R11

  AST_DRIVE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_o |-> busy_o);  // R10

  AST_BUSY_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(pin_level_i));  // R1

  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en_o) |-> !drive_val_o);  // R5

  AST_LOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o && drive_val_o) |-> (low_run_q == RW'(PULSE_LOW_CYCLES)));  // R5

  AST_SPEEDUP_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o && drive_val_o) |-> $past(drive_en_o && !drive_val_o));  // R6

  AST_RELEASE_AFTER_SPEEDUP: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o && drive_val_o) |=> (!drive_en_o && !busy_o));  // R7

endmodule

bind sync_pulse_responder sync_pulse_responder_chk #(
  .PULSE_LOW_CYCLES (PULSE_LOW_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_level_i (pin_level_i),
  .drive_en_o  (drive_en_o),
  .drive_val_o (drive_val_o),
  .busy_o      (busy_o)
);

// File: tb/sync_pulse_responder_tb_top.sv
`timescale 1ns/1ps
module sync_pulse_responder_tb_top;

  localparam int unsigned SYNC   = 8;
  localparam int unsigned SETTLE = 4;
  localparam int unsigned LOWN   = 6;

  logic clk;
  logic rst_n;
  logic host_lvl;
  logic pin_level;
  logic drive_en;
  logic drive_val;
  logic busy;

  int checks;
  int fails;
  bit done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Pad model: target drive wins, else host level (1 = released, pulled up)
  assign pin_level = drive_en ? drive_val : host_lvl;

  sync_pulse_responder #(
    .SYNC_LOW_CYCLES  (SYNC),
    .SETTLE_CYCLES    (SETTLE),
    .PULSE_LOW_CYCLES (LOWN)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_level_i (pin_level),
    .drive_en_o  (drive_en),
    .drive_val_o (drive_val),
    .busy_o      (busy)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Host holds pin low for n clock edges, checking busy/drive each cycle
  task automatic hold_low(input int n);
    host_lvl = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i < int'(SYNC))       check_eq("R2 busy during short low", busy, 0);
      else if (i == int'(SYNC)) check_eq("R1 busy at threshold", busy, 1);
      else                      check_eq("R3 busy while low persists", busy, 1);
      check_eq("R3 no drive before high", drive_en, 0);
    end
    host_lvl = 1'b1;
  endtask

  // Measure one reply after the host released the pin at a negedge
  task automatic measure(input bit host_low_in_settle);
    int settle = 0;
    int lows = 0;
    int highs = 0;
    int order_err = 0;
    bit ended = 0;
    for (int k = 0; k < int'(4 * (SETTLE + LOWN) + 10); k++) begin
      @(negedge clk);
      if (drive_en && !busy) order_err++;
      if (busy && !drive_en) begin
        if (lows == 0 && highs == 0) begin
          settle++;
          if (host_low_in_settle && settle == 2) host_lvl = 1'b0;
        end else order_err++;
      end else if (drive_en && !drive_val) begin
        if (highs != 0) order_err++;
        lows++;
      end else if (drive_en && drive_val) begin
        highs++;
      end else begin
        ended = 1;
        break;
      end
    end
    check_eq(host_low_in_settle ? "R8 settle length with host low" : "R4 settle length",
             settle, SETTLE);
    check_eq(host_low_in_settle ? "R8 low length with host low" : "R5 low length",
             lows, LOWN);
    check_eq("R6 speedup length", highs, 1);
    check_eq("R7 released", int'(ended && !drive_en && !busy), 1);
    check_eq("R10 phase order and busy cover", order_err, 0);
  endtask

  // No response expected after a short low
  task automatic quiet_window();
    int seen = 0;
    for (int k = 0; k < int'(SETTLE + LOWN + 4); k++) begin
      @(negedge clk);
      if (busy || drive_en) seen++;
    end
    check_eq("R2 short low ignored", seen, 0);
  endtask

  initial begin
    checks   = 0;
    fails    = 0;
    done     = 0;
    host_lvl = 1'b1;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R11 reset drive_en", drive_en, 0);
    check_eq("R11 reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Threshold sweep around SYNC
    for (int len = 1; len <= int'(SYNC) + 3; len++) begin
      hold_low(len);
      if (len >= int'(SYNC)) measure(1'b0);
      else quiet_window();
      repeat (2) @(negedge clk);
    end

    // Host low during settle and past release: ignored, no re-arm
    hold_low(SYNC);
    measure(1'b1);
    for (int i = 0; i < int'(SYNC) + 3; i++) begin
      @(negedge clk);
      check_eq("R9 no re-arm while low after release", int'(busy || drive_en), 0);
    end
    host_lvl = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R9 idle after high seen", busy, 0);
    hold_low(SYNC);
    measure(1'b0);
    repeat (2) @(negedge clk);

    // Reset in the middle of the low drive
    hold_low(SYNC);
    repeat (SETTLE + 2) @(negedge clk);
    check_eq("R5 driving low before reset", int'(drive_en && !drive_val), 1);
    rst_n = 1'b0;
    #1;
    check_eq("R11 async clear drive_en", drive_en, 0);
    check_eq("R11 async clear busy", busy, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R11 idle right after release", int'(busy || drive_en), 0);
    repeat (3) @(negedge clk);
    hold_low(SYNC);
    measure(1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule